// File: doc/BRIEF.md
# Sensor Payload Pixel Unpacker

This block sits behind the packet delimiter of one serial sensor lane. It takes the 32-bit words of a packet, with pad symbols already removed, and a packet-enable signal that is high from the start code to the end code. The first two valid words of each packet form a 64-bit header. The header is kept and shown on its own port. Its top bits give the frame and line framing of the packet.

Every later word is payload. Payload bits are gathered little-endian into a residue register. Each time four whole pixels of `DATA_WIDTH` bits are held, they are sent out together on one beat of a packed bus, with the oldest pixel in the LSBs. A line-valid strobe marks beats that carry active video. An embedded-data strobe marks beats from embedded-data packets. A frame-valid level is set by the frame-start bit and cleared at the end of a packet whose header carries the frame-end bit.

Top module: `pix_unpacker`

## Requirements
- R1: While reset is held and just after it, every output is zero.
- R2: The first valid word of a packet becomes header bits 31:0 and the second becomes bits 63:32. `hdr_o` shows the whole header on the cycle after the second word and does not change after the first word alone.
- R3: Payload words are joined bit by bit, with the first word in the lowest bits. Each group of 4×DATA_WIDTH bits is put on `pix_o` one cycle after the word that completes it. Pixel 0 is in bits DATA_WIDTH-1:0 and the newest pixel is in the MSBs.
- R4: `line_vld_o` is high on exactly those beats that carry a new group from a packet whose header has bit 61 set and bit 60 clear.
- R5: `ebd_vld_o` is high on exactly those beats that carry a new group from a packet whose header has bit 60 set. It is never high together with `line_vld_o`.
- R6: `frame_vld_o` rises on the cycle after a second header word whose bit 31 (header bit 63, frame start) is set.
- R7: `frame_vld_o` falls on the cycle after `pkt_en` is first sampled low, when the packet that just ended had a complete header with bit 62 (frame end) set. When both bits are set, the frame is entered at the header and left at packet end.
- R8: Bits left over that do not fill a whole group are dropped at packet end. The first group of the next packet starts at that packet's first payload bit.
- R9: A word with `word_vld` low, or with `pkt_en` low, changes no output and is not taken as header or payload.
- R10: `pix_o` keeps its last group on every beat that brings no new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_en | input | 1 | High for the whole packet, from start code to end code |
| word_vld | input | 1 | `word_i` holds a valid packet word |
| word_i | input | 32 | Pad-stripped packet word |
| hdr_o | output | 64 | Header captured from the last packet |
| pix_o | output | 4×DATA_WIDTH | Four packed pixels, newest in the MSBs |
| line_vld_o | output | 1 | Beat carries active-line pixels |
| frame_vld_o | output | 1 | Inside a frame |
| ebd_vld_o | output | 1 | Beat carries embedded data |

## Verification
The hardest state to reach is a packet that ends while part of a pixel is still held in the residue register. The next packet must then start on a clean bit boundary. With 10-bit pixels a group is 40 bits, and a 32-bit word stream only lines up with it every five words. So the stimulus uses payload lengths that are not multiples of five, gaps inside packets, and packets with a single payload word. Each packet's first group is checked against a bit stream that starts fresh.

// File: rtl/pix_unpacker.sv
module pix_unpacker #(
  parameter int DATA_WIDTH = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pkt_en,
  input  logic                    word_vld,
  input  logic [31:0]             word_i,
  output logic [63:0]             hdr_o,
  output logic [4*DATA_WIDTH-1:0] pix_o,
  output logic                    line_vld_o,
  output logic                    frame_vld_o,
  output logic                    ebd_vld_o
);
  localparam int GRP = 4 * DATA_WIDTH;
  localparam int CW  = $clog2(GRP + 33);

  logic [GRP-1:0]    res;
  logic [CW-1:0]     cnt;
  logic [1:0]        hcnt;
  logic [31:0]       hdr_lo;
  logic              hdr_ok, in_pkt;
  logic [GRP+31:0]   merged;
  logic [CW-1:0]     total;
  logic              take, pay, emit;

  assign take   = pkt_en & word_vld;
  assign pay    = take & (hcnt == 2'd2);
  assign merged = {32'b0, res} | ({{GRP{1'b0}}, word_i} << cnt);
  assign total  = cnt + (pay ? CW'(32) : CW'(0));
  assign emit   = pay & (total >= CW'(GRP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res         <= '0;
      cnt         <= '0;
      hcnt        <= '0;
      hdr_lo      <= '0;
      hdr_ok      <= 1'b0;
      in_pkt      <= 1'b0;
      hdr_o       <= '0;
      pix_o       <= '0;
      line_vld_o  <= 1'b0;
      frame_vld_o <= 1'b0;
      ebd_vld_o   <= 1'b0;
    end else begin
      in_pkt     <= pkt_en;
      line_vld_o <= 1'b0;
      ebd_vld_o  <= 1'b0;
      if (!pkt_en) begin
        res  <= '0;
        cnt  <= '0;
        hcnt <= '0;
        if (in_pkt) begin
          hdr_ok <= 1'b0;
          if (hdr_ok && hdr_o[62]) frame_vld_o <= 1'b0;
        end
      end else if (take) begin
        if (hcnt == 2'd0) begin
          hdr_lo <= word_i;
          hcnt   <= 2'd1;
        end else if (hcnt == 2'd1) begin
          hdr_o  <= {word_i, hdr_lo};
          hcnt   <= 2'd2;
          hdr_ok <= 1'b1;
          if (word_i[31]) frame_vld_o <= 1'b1;
        end else if (emit) begin
          pix_o      <= merged[GRP-1:0];
          res        <= {{(GRP-32){1'b0}}, merged[GRP +: 32]};
          cnt        <= total - CW'(GRP);
          line_vld_o <= hdr_o[61] & ~hdr_o[60];
          ebd_vld_o  <= hdr_o[60];
        end else begin
          res <= merged[GRP-1:0];
          cnt <= total;
        end
      end
    end
  end
endmodule

// File: rtl/pix_unpacker_chk.sv
module pix_unpacker_chk #(
  parameter int DATA_WIDTH = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pkt_en,
  input logic                    word_vld,
  input logic [63:0]             hdr_o,
  input logic [4*DATA_WIDTH-1:0] pix_o,
  input logic                    line_vld_o,
  input logic                    frame_vld_o,
  input logic                    ebd_vld_o
);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_vld_o && ebd_vld_o));

  p_line_needs_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_vld_o |-> $past(pkt_en && word_vld));

  p_ebd_needs_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ebd_vld_o |-> $past(pkt_en && word_vld));

  p_frame_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_vld_o) |-> $past(pkt_en && word_vld));

  p_frame_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_vld_o) |-> $past(!pkt_en));

  p_pix_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pkt_en && word_vld) |-> $stable(pix_o));

  p_hdr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pkt_en && word_vld) |-> $stable(hdr_o));
endmodule

bind pix_unpacker pix_unpacker_chk #(.DATA_WIDTH(DATA_WIDTH)) u_chk (.*);

// File: tb/pix_unpacker_tb.sv
module pix_unpacker_tb;
  localparam int DW = 10;
  localparam int G  = 4 * DW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pkt_en, word_vld;
  logic [31:0]   word_i;
  logic [63:0]   hdr_o;
  logic [G-1:0]  pix_o;
  logic          line_vld_o, frame_vld_o, ebd_vld_o;

  always #2.5 clk = ~clk;

  pix_unpacker #(.DATA_WIDTH(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_en(pkt_en), .word_vld(word_vld),
    .word_i(word_i), .hdr_o(hdr_o), .pix_o(pix_o), .line_vld_o(line_vld_o),
    .frame_vld_o(frame_vld_o), .ebd_vld_o(ebd_vld_o)
  );

  int errs = 0, checks = 0;
  bit done = 1'b0;
  logic [31:0] pw [64];
  int npw, ng, hw;
  logic [63:0] ehdr;
  logic [31:0] elo;
  logic ehv, efv, inpkt, prevres;
  logic [G-1:0] lastpix;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [G-1:0] grp(input int k);
    logic [G-1:0] r;
    for (int b = 0; b < G; b++) r[b] = pw[(k*G+b)/32][(k*G+b)%32];
    return r;
  endfunction

  task automatic cyc(input logic pen, input logic vld, input logic [31:0] w);
    logic emit;
    logic [G-1:0] eg;
    string pr;
    pkt_en = pen; word_vld = vld; word_i = w;
    @(posedge clk);
    @(negedge clk);
    emit = 1'b0;
    eg = lastpix;
    pr = "R10";
    if (!pen) begin
      if (inpkt) begin
        if (ehv && ehdr[62]) efv = 1'b0;
        ehv = 1'b0;
        prevres = (npw * 32) != (ng * G);
      end
      hw = 0; npw = 0; ng = 0;
    end else if (vld) begin
      if (hw == 0) begin
        elo = w; hw = 1;
      end else if (hw == 1) begin
        ehdr = {w, elo}; hw = 2; ehv = 1'b1;
        if (w[31]) efv = 1'b1;
      end else begin
        pw[npw] = w; npw++;
        if (npw * 32 >= (ng + 1) * G) begin
          emit = 1'b1;
          eg = grp(ng);
          pr = (ng == 0 && prevres) ? "R8" : "R3";
          ng++;
        end
      end
    end
    inpkt = pen;
    check(pr, 64'(pix_o), 64'(eg));
    lastpix = eg;
    check("R4", 64'(line_vld_o), 64'(emit & ehdr[61] & ~ehdr[60]));
    check("R5", 64'(ebd_vld_o), 64'(emit & ehdr[60]));
    check("R6/R7", 64'(frame_vld_o), 64'(efv));
    check((pen && vld) ? "R2" : "R9", hdr_o, ehdr);
  endtask

  task automatic pkt(input logic [63:0] h, input int n);
    for (int i = 0; i < 2; i++) begin
      while ($urandom % 4 == 0) cyc(1'b1, 1'b0, $urandom);
      cyc(1'b1, 1'b1, h[32*i +: 32]);
    end
    for (int i = 0; i < n; i++) begin
      while ($urandom % 4 == 0) cyc(1'b1, 1'b0, $urandom);
      cyc(1'b1, 1'b1, $urandom);
    end
    cyc(1'b0, 1'($urandom), $urandom);
    if ($urandom % 2 == 0) cyc(1'b0, 1'b1, $urandom);
  endtask

  function automatic logic [63:0] mkhdr(input logic fs, input logic fe, input logic lv, input logic eb);
    return {fs, fe, lv, eb, 28'($urandom), 32'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    npw = 0; ng = 0; hw = 0; ehdr = '0; elo = '0;
    ehv = 1'b0; efv = 1'b0; inpkt = 1'b0; prevres = 1'b0; lastpix = '0;
    rst_n = 1'b0; pkt_en = 1'b0; word_vld = 1'b0; word_i = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", hdr_o, 64'h0);
    check("R1", 64'(pix_o), 64'h0);
    check("R1", 64'({line_vld_o, frame_vld_o, ebd_vld_o}), 64'h0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b1, 32'hFFFF_FFFF);
    pkt(mkhdr(1, 0, 1, 0), 10);
    pkt(mkhdr(0, 0, 1, 0), 7);
    pkt(mkhdr(0, 0, 0, 1), 3);
    pkt(mkhdr(0, 1, 1, 0), 4);
    pkt(mkhdr(1, 1, 1, 0), 1);
    pkt(mkhdr(1, 0, 1, 0), 6);
    pkt(mkhdr(0, 0, 0, 0), 5);
    pkt(mkhdr(0, 1, 0, 1), 2);
    for (int p = 0; p < 80; p++)
      pkt(mkhdr(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom)), 1 + int'($urandom % 30));
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule